// File: doc/BRIEF.md
# Level-Adaptive Driver Code Generator

This block feeds the impedance-control codes of a single-ended four-level (PAM-4) voltage-mode output driver. It holds two small tables, one for pull-up codes and one for pull-down codes. Each table has one entry for every output level. During a calibration phase, before any data is sent, software or a training engine fills the tables through a simple write port. The calibration measurement itself lies outside this block.

During transmission, the two-bit symbol (MSB and LSB) chooses one pull-up code and one pull-down code in every unit interval. The driver therefore gets a code pair calibrated for the level it is about to produce. The codes are registered. The symbol passes through a matching register, so the codes and the data arrive at the driver in the same cycle. A fixed-code mode applies one chosen code pair whatever the data is, which gives a baseline to compare against the adaptive mode.

Top module: `lvl_code_gen`

## Requirements
- R1: After reset every table entry holds mid-scale 5'b10000, and `pu_code`, `pd_code` and `sym_out` are all zero.
- R2: On the clock edge after a cycle with `tx_en` low, `pu_code` and `pd_code` are 5'b00000.
- R3: A cycle with `wr_en` high and `tx_en` low stores `wr_data` into entry `wr_lvl`. The entry goes to the pull-down table when `wr_is_pd` is 1 and to the pull-up table when it is 0.
- R4: A write request made while `tx_en` is high is ignored, and the addressed entry keeps its earlier value.
- R5: With `tx_en` high and `fixed_mode` low, one cycle after `sym_in` = s, `pu_code` and `pd_code` equal the entries at index s of the pull-up and pull-down tables. Symbol value 3 (MSB=1, LSB=1) indexes entry 3, and so on down to 0.
- R6: `sym_out` equals `sym_in` from one cycle earlier, so it lines up with the codes that `sym_in` selected.
- R7: With `tx_en` and `fixed_mode` high, the codes equal the entries at index `fixed_sel`, whatever `sym_in` is.
- R8: A write to one table leaves the other table unchanged.
- R9: With pull-down entries 3..0 loaded as 01010, 10010, 10011, 10111, the symbols 11, 10, 01, 00 produce exactly those pull-down codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmission enable; also blocks table writes |
| fixed_mode | input | 1 | 1 = apply one code pair regardless of data |
| fixed_sel | input | 2 | Entry used in fixed mode |
| sym_in | input | 2 | Current symbol {MSB, LSB} |
| wr_en | input | 1 | Table write request |
| wr_lvl | input | 2 | Entry index to write |
| wr_is_pd | input | 1 | 1 = pull-down table, 0 = pull-up table |
| wr_data | input | 5 | Code to store |
| sym_out | output | 2 | Symbol delayed to match the codes |
| pu_code | output | 5 | Pull-up driver code |
| pd_code | output | 5 | Pull-down driver code |

## Verification
The stability properties assume that the tables change only while transmission is off. They also assume that `fixed_sel` and `sym_in` change only at the cycle boundaries the properties look at. The bench keeps to this by doing all of its writes with `tx_en` low, except the one deliberate write during transmission that must be rejected. It also drives every input on the falling clock edge, so no input changes near the sampling edge.

// File: rtl/lvl_code_pkg.sv
`timescale 1ns/1ps
package lvl_code_pkg;
    localparam int CODE_W   = 5;
    localparam int LEVELS   = 4;
    localparam int SYM_W    = $clog2(LEVELS);
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SYM_W-1:0]  sym_t;

    // both code tables, one packed entry per output level
    typedef struct packed {
        code_t [LEVELS-1:0] pu;
        code_t [LEVELS-1:0] pd;
    } tables_t;

    // registered outputs toward the driver
    typedef struct packed {
        code_t pu;
        code_t pd;
        sym_t  sym;
    } drv_regs_t;
endpackage

// File: rtl/lvl_code_table.sv
`timescale 1ns/1ps
module lvl_code_table
    import lvl_code_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_en,
    input  logic               wr_en,
    input  sym_t               wr_lvl,
    input  logic               wr_is_pd,
    input  code_t              wr_data,
    output code_t [LEVELS-1:0] pu_tab,
    output code_t [LEVELS-1:0] pd_tab
);
    tables_t tab_d, tab_q;
    logic    wr_ok;

    // writes are only taken while the driver is idle
    assign wr_ok = wr_en & ~tx_en;

    always_comb begin
        tab_d = tab_q;
        if (wr_ok) begin
            if (wr_is_pd) tab_d.pd[wr_lvl] = wr_data;
            else          tab_d.pu[wr_lvl] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LEVELS; i++) begin
                tab_q.pu[i] <= MID_CODE;
                tab_q.pd[i] <= MID_CODE;
            end
        end else begin
            tab_q <= tab_d;
        end
    end

    assign pu_tab = tab_q.pu;
    assign pd_tab = tab_q.pd;
endmodule

// File: rtl/lvl_code_mux.sv
`timescale 1ns/1ps
module lvl_code_mux
    import lvl_code_pkg::*;
(
    input  code_t [LEVELS-1:0] tab,
    input  sym_t               sel,
    output code_t              code
);
    // one LEVELS-to-1 selector per code bit
    for (genvar b = 0; b < CODE_W; b++) begin : g_bit
        logic [LEVELS-1:0] column;
        for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
            assign column[l] = tab[l][b];
        end
        assign code[b] = column[sel];
    end
endmodule

// File: rtl/lvl_code_gen.sv
`timescale 1ns/1ps
module lvl_code_gen
    import lvl_code_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_en,
    input  logic        fixed_mode,
    input  logic [1:0]  fixed_sel,
    input  logic [1:0]  sym_in,
    input  logic        wr_en,
    input  logic [1:0]  wr_lvl,
    input  logic        wr_is_pd,
    input  logic [4:0]  wr_data,
    output logic [1:0]  sym_out,
    output logic [4:0]  pu_code,
    output logic [4:0]  pd_code
);
    code_t [LEVELS-1:0] pu_tab, pd_tab;
    sym_t               sel;
    code_t              pu_pick, pd_pick;
    drv_regs_t          drv_d, drv_q;

    lvl_code_table u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .wr_en    (wr_en),
        .wr_lvl   (wr_lvl),
        .wr_is_pd (wr_is_pd),
        .wr_data  (wr_data),
        .pu_tab   (pu_tab),
        .pd_tab   (pd_tab)
    );

    // the fixed mode replaces the data-driven select
    assign sel = fixed_mode ? fixed_sel : sym_in;

    lvl_code_mux u_pu_mux (.tab(pu_tab), .sel(sel), .code(pu_pick));
    lvl_code_mux u_pd_mux (.tab(pd_tab), .sel(sel), .code(pd_pick));

    always_comb begin
        drv_d     = drv_q;
        drv_d.sym = sym_in;
        drv_d.pu  = tx_en ? pu_pick : '0;
        drv_d.pd  = tx_en ? pd_pick : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drv_q <= '0;
        else        drv_q <= drv_d;
    end

    assign sym_out = drv_q.sym;
    assign pu_code = drv_q.pu;
    assign pd_code = drv_q.pd;
endmodule

// File: rtl/lvl_code_gen_chk.sv
`timescale 1ns/1ps
module lvl_code_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_en,
    input logic       fixed_mode,
    input logic [1:0] fixed_sel,
    input logic [1:0] sym_in,
    input logic [1:0] sym_out,
    input logic [4:0] pu_code,
    input logic [4:0] pd_code
);
    // R2: idle cycle gives zero codes next cycle
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (pu_code == 5'd0 && pd_code == 5'd0));

    // R6: delayed symbol follows the input by one cycle
    p_sym_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sym_out == $past(sym_in)));

    // R7 and R4: fixed mode with writes blocked holds the codes
    p_fixed_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && fixed_mode && $past(tx_en) && $past(fixed_mode) && $stable(fixed_sel))
        |=> ($stable(pu_code) && $stable(pd_code)));

    // R5: a repeated symbol during transmission repeats the codes
    p_same_sym_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !fixed_mode && $past(tx_en) && !$past(fixed_mode) && $stable(sym_in))
        |=> ($stable(pu_code) && $stable(pd_code)));
endmodule

bind lvl_code_gen lvl_code_gen_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .fixed_mode (fixed_mode),
    .fixed_sel  (fixed_sel),
    .sym_in     (sym_in),
    .sym_out    (sym_out),
    .pu_code    (pu_code),
    .pd_code    (pd_code)
);

// File: tb/lvl_code_gen_tb_top.sv
`timescale 1ns/1ps
module lvl_code_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       fixed_mode = 1'b0;
    logic [1:0] fixed_sel = 2'd0;
    logic [1:0] sym_in = 2'd0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_lvl = 2'd0;
    logic       wr_is_pd = 1'b0;
    logic [4:0] wr_data = 5'd0;
    logic [1:0] sym_out;
    logic [4:0] pu_code, pd_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lvl_code_gen dut_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .fixed_mode(fixed_mode),
        .fixed_sel(fixed_sel), .sym_in(sym_in), .wr_en(wr_en), .wr_lvl(wr_lvl),
        .wr_is_pd(wr_is_pd), .wr_data(wr_data), .sym_out(sym_out),
        .pu_code(pu_code), .pd_code(pd_code)
    );

    // {symbol, expected pull-up, expected pull-down}
    localparam logic [11:0] VEC [8] = '{
        {2'd3, 5'b00011, 5'b01010},
        {2'd2, 5'b00110, 5'b10010},
        {2'd1, 5'b01100, 5'b10011},
        {2'd0, 5'b11001, 5'b10111},
        {2'd0, 5'b11001, 5'b10111},
        {2'd3, 5'b00011, 5'b01010},
        {2'd1, 5'b01100, 5'b10011},
        {2'd2, 5'b00110, 5'b10010}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic write_entry(input logic [1:0] lvl, input logic pd, input logic [4:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_lvl = lvl; wr_is_pd = pd; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // drive a symbol, then sample just after the registering edge
    task automatic send(input logic [1:0] s);
        @(negedge clk);
        sym_in = s;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk("R1 pu reset", {3'b0, pu_code}, 8'd0);
        chk("R1 pd reset", {3'b0, pd_code}, 8'd0);
        chk("R1 sym reset", {6'b0, sym_out}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // mid-scale contents visible once enabled
        @(negedge clk); tx_en = 1'b1;
        send(2'd2);
        chk("R1 pu mid-scale", {3'b0, pu_code}, 8'b00010000);
        chk("R1 pd mid-scale", {3'b0, pd_code}, 8'b00010000);

        // calibration load (R3)
        @(negedge clk); tx_en = 1'b0;
        write_entry(2'd0, 1'b0, 5'b11001);
        write_entry(2'd1, 1'b0, 5'b01100);
        write_entry(2'd2, 1'b0, 5'b00110);
        write_entry(2'd3, 1'b0, 5'b00011);
        write_entry(2'd0, 1'b1, 5'b10111);
        write_entry(2'd1, 1'b1, 5'b10011);
        write_entry(2'd2, 1'b1, 5'b10010);
        write_entry(2'd3, 1'b1, 5'b01010);
        send(2'd3);
        chk("R2 pu idle", {3'b0, pu_code}, 8'd0);
        chk("R2 pd idle", {3'b0, pd_code}, 8'd0);

        // adaptive walk: R3 R5 R6 R9
        @(negedge clk); tx_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            send(VEC[i][11:10]);
            chk("R5 R3 pu select", {3'b0, pu_code}, {3'b0, VEC[i][9:5]});
            chk("R9 pd select", {3'b0, pd_code}, {3'b0, VEC[i][4:0]});
            chk("R6 sym align", {6'b0, sym_out}, {6'b0, VEC[i][11:10]});
        end

        // R4: write during transmission is dropped
        write_entry(2'd2, 1'b0, 5'b11111);
        send(2'd2);
        chk("R4 write ignored", {3'b0, pu_code}, 8'b00000110);

        // R7: fixed mode on entry 1
        @(negedge clk); fixed_mode = 1'b1; fixed_sel = 2'd1;
        for (int s = 0; s < 4; s++) begin
            send(2'(s));
            chk("R7 fixed pu", {3'b0, pu_code}, 8'b00001100);
            chk("R7 fixed pd", {3'b0, pd_code}, 8'b00010011);
        end
        @(negedge clk); fixed_mode = 1'b0;

        // R8: pull-up write leaves pull-down alone
        @(negedge clk); tx_en = 1'b0;
        write_entry(2'd0, 1'b0, 5'b00000);
        @(negedge clk); tx_en = 1'b1;
        send(2'd0);
        chk("R8 pu updated", {3'b0, pu_code}, 8'd0);
        chk("R8 pd untouched", {3'b0, pd_code}, 8'b00010111);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule